// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits between a host bus and the program/erase engine of a NOR-style flash array. It reads every write cycle on a synchronous write strobe and decodes the command byte in the low half of the data word. Some commands take effect on the spot: they select a read mode, clear the error flags, or suspend or resume an operation. Others need two writes: the first opens a command and the second confirms it or carries its payload. A sequence that is accepted becomes a one-cycle start request to the back end, carrying the operation kind, the target address and the data word. A sequence that is rejected records an error flag and changes nothing else.

The block keeps one lock bit for each block and one permanent lock bit. Erase and program requests aimed at locked storage are refused. Once the permanent lock is set, the block lock bits are frozen. The read port is combinational. It returns the array data from outside the block, the identifier space, or the status word, depending on the current read mode. While an operation is running, the read port always returns the status word.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read mode is array (the read port returns `arrayData`), the status word is 0x0080, all lock bits are clear and no request output is high.
- R2: Only the low data byte is decoded as a command, and the address does not matter for it. 0xFF selects array reads, 0x90 selects identifier reads and 0x70 selects status reads. The status word is {8'h00, ready[7], suspended[6], eraseErr[5], progErr[4], seqErr[3], 0, lockErr[1], 0}.
- R3: Identifier reads return a 16-bit word. Word address 0 gives 0x00B0 and address 1 gives 0x00E9. Address 3 gives the permanent lock in bit 0. Any other address with in-block offset 2 gives that block's lock bit in bit 0. Every other address reads 0.
- R4: 0x20 followed by 0xD0 pulses `opStart` for one cycle, with `opKind`=0 and `opAddr` equal to the confirm address. 0x30 followed by 0xD0 pulses it with `opKind`=1. Both sequences switch the read mode to status.
- R5: 0x40 or 0x10 followed by any word pulses `opStart` with `opKind`=2, and `opAddr`/`opData` equal to the address and data of the second write.
- R6: An erase or lock sequence whose second byte is not a valid confirm code (not 0xD0 for erase; not 0x01, 0xD0 or 0xF1 for lock) sets seqErr, selects status mode, issues no request and leaves the lock bits unchanged.
- R7: An erase or program whose target block is locked, or a chip erase while any block is locked, is refused: lockErr is set and no request is issued.
- R8: 0x60 followed by 0x01 sets the lock bit of the addressed block. 0x60 followed by 0xD0 clears every block lock bit. 0x60 followed by 0xF1 sets the permanent lock.
- R9: While the permanent lock is set, set-block-lock and clear-all-locks are refused with lockErr, and the block lock bits do not change.
- R10: From a request until completion, status bit 7 is 0 and the read port returns the status word in every mode. Only 0xB0 and 0x70 are accepted during that time; every other write has no effect.
- R11: 0xB0 during a running operation pulses `suspendReq`, and the status then shows bits 7 and 6 set. While suspended, 0xD0 pulses `resumeReq`, and opening commands 0x20, 0x30, 0x40, 0x10 and 0x60 are ignored.
- R12: `opDone` ends the operation. If `opErr` is high with it, eraseErr is set for kinds 0 and 1, and progErr for kind 2.
- R13: 0x50 clears bits 5, 4, 3 and 1 of the status word and leaves bits 7 and 6 as they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write cycle strobe |
| wrAddr | input | ADDR_W | Word address of the write |
| wrData | input | 16 | Write data; command byte in bits 7:0 |
| rdAddr | input | ADDR_W | Word address of the read |
| rdData | output | 16 | Read data for the current mode |
| arrayData | input | 16 | Array word from outside, returned in array mode |
| opStart | output | 1 | One-cycle start request to the back end |
| opKind | output | 2 | 0 block erase, 1 chip erase, 2 program |
| opAddr | output | ADDR_W | Target address of the request |
| opData | output | 16 | Program data of the request |
| suspendReq | output | 1 | One-cycle suspend request |
| resumeReq | output | 1 | One-cycle resume request |
| opDone | input | 1 | Back end finished the operation |
| opErr | input | 1 | Operation failed; valid with opDone |

## Verification
The second byte of a block erase is swept through all 256 values. Only 0xD0 may produce a request, and every other value must produce a sequence error. The full identifier space is swept after each lock change and compared with an arithmetic model, so a lock status read from the wrong block or offset shows up. Busy and suspended runs use writes that an idle sequencer would accept: a wrongly accepted command leaves a visible trace, such as a new lock bit, an identifier read, or an erase start triggered by the resume code.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
  localparam logic [7:0] CMD_ERASE_BLK  = 8'h20;
  localparam logic [7:0] CMD_ERASE_CHIP = 8'h30;
  localparam logic [7:0] CMD_PROG_A     = 8'h40;
  localparam logic [7:0] CMD_PROG_B     = 8'h10;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_LOCK       = 8'h60;
  localparam logic [7:0] SUB_SET_BLK    = 8'h01;
  localparam logic [7:0] SUB_SET_PERM   = 8'hF1;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} readMode_e;
  typedef enum logic [1:0] {OP_BLK_ERASE = 2'd0, OP_CHIP_ERASE = 2'd1, OP_PROGRAM = 2'd2} opKind_e;

  typedef struct packed {
    logic      setBlkLock;
    logic      clrAllLocks;
    logic      setPermLock;
    logic      setSeqErr;
    logic      setLockErr;
    logic      setEraseErr;
    logic      setProgErr;
    logic      clrErr;
    logic      busy;
    logic      suspended;
    readMode_e mode;
  } seqStrobes_t;
endpackage

// File: rtl/fcs_control.sv
`timescale 1ns/1ps
module fcs_control
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic              opDone,
  input  logic              opErr,
  input  logic              targetLocked,
  input  logic              anyLocked,
  input  logic              permLocked,
  output seqStrobes_t       strobes,
  output logic              opStart,
  output logic [1:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [15:0]       opData,
  output logic              suspendReq,
  output logic              resumeReq
);
  typedef enum logic [2:0] {ST_IDLE, ST_ERASE, ST_CHIP, ST_PROG, ST_LOCK} seqState_e;

  seqState_e state, stateN;
  readMode_e mode, modeN;
  opKind_e   curKind, kindN;
  logic      busy, busyN, suspended, suspN;
  logic      startN, suspPN, resPN;
  logic [7:0] cmd;
  logic      running;

  assign cmd     = wrData[7:0];
  assign running = busy && !suspended;
  assign opKind  = curKind;

  always_comb begin
    stateN = state; modeN = mode; kindN = curKind;
    busyN = busy; suspN = suspended;
    startN = 1'b0; suspPN = 1'b0; resPN = 1'b0;
    strobes = '0;
    if (wrEn) begin
      case (state)
        ST_IDLE: begin
          if (running) begin
            if (cmd == CMD_SUSPEND) begin
              suspN = 1'b1; suspPN = 1'b1; modeN = RM_STATUS;
            end else if (cmd == CMD_READ_STAT) begin
              modeN = RM_STATUS;
            end
          end else begin
            case (cmd)
              CMD_READ_ARRAY: modeN = RM_ARRAY;
              CMD_READ_ID:    modeN = RM_IDENT;
              CMD_READ_STAT:  modeN = RM_STATUS;
              CMD_CLR_STAT:   strobes.clrErr = 1'b1;
              CMD_CONFIRM: if (suspended) begin
                suspN = 1'b0; resPN = 1'b1; modeN = RM_STATUS;
              end
              CMD_ERASE_BLK:  if (!suspended) stateN = ST_ERASE;
              CMD_ERASE_CHIP: if (!suspended) stateN = ST_CHIP;
              CMD_PROG_A, CMD_PROG_B: if (!suspended) stateN = ST_PROG;
              CMD_LOCK:       if (!suspended) stateN = ST_LOCK;
              default: ;
            endcase
          end
        end
        ST_ERASE, ST_CHIP: begin
          stateN = ST_IDLE; modeN = RM_STATUS;
          if (cmd != CMD_CONFIRM) strobes.setSeqErr = 1'b1;
          else if ((state == ST_ERASE) ? targetLocked : anyLocked) strobes.setLockErr = 1'b1;
          else begin
            startN = 1'b1; busyN = 1'b1;
            kindN = (state == ST_ERASE) ? OP_BLK_ERASE : OP_CHIP_ERASE;
          end
        end
        ST_PROG: begin
          stateN = ST_IDLE; modeN = RM_STATUS;
          if (targetLocked) strobes.setLockErr = 1'b1;
          else begin startN = 1'b1; busyN = 1'b1; kindN = OP_PROGRAM; end
        end
        ST_LOCK: begin
          stateN = ST_IDLE; modeN = RM_STATUS;
          case (cmd)
            SUB_SET_BLK:  if (permLocked) strobes.setLockErr = 1'b1; else strobes.setBlkLock = 1'b1;
            CMD_CONFIRM:  if (permLocked) strobes.setLockErr = 1'b1; else strobes.clrAllLocks = 1'b1;
            SUB_SET_PERM: strobes.setPermLock = 1'b1;
            default:      strobes.setSeqErr = 1'b1;
          endcase
        end
        default: stateN = ST_IDLE;
      endcase
    end
    if (opDone && busy) begin
      busyN = 1'b0; suspN = 1'b0; suspPN = 1'b0;
      if (opErr) begin
        if (curKind == OP_PROGRAM) strobes.setProgErr = 1'b1;
        else strobes.setEraseErr = 1'b1;
      end
    end
    strobes.busy = busy;
    strobes.suspended = suspended;
    strobes.mode = mode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; mode <= RM_ARRAY; curKind <= OP_BLK_ERASE;
      busy <= 1'b0; suspended <= 1'b0;
      opStart <= 1'b0; suspendReq <= 1'b0; resumeReq <= 1'b0;
      opAddr <= '0; opData <= '0;
    end else begin
      state <= stateN; mode <= modeN; curKind <= kindN;
      busy <= busyN; suspended <= suspN;
      opStart <= startN; suspendReq <= suspPN; resumeReq <= resPN;
      if (startN) begin
        opAddr <= wrAddr; opData <= wrData;
      end
    end
  end

  assert_req_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opStart, suspendReq, resumeReq}));
  assert_start_running_R4: assert property (@(posedge clk) disable iff (!rstN)
    opStart |-> (busy && !suspended));
  assert_suspend_state_R11: assert property (@(posedge clk) disable iff (!rstN)
    suspendReq |-> (busy && suspended));
  assert_resume_state_R11: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq |-> (busy && !suspended));
  assert_pending_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !busy);
endmodule

// File: rtl/fcs_datapath.sv
`timescale 1ns/1ps
module fcs_datapath
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_BLOCKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [15:0]       arrayData,
  output logic [15:0]       rdData,
  output logic              targetLocked,
  output logic              anyLocked,
  output logic              permLocked
);
  localparam int BLK_W  = $clog2(NUM_BLOCKS);
  localparam int OFFS_W = ADDR_W - BLK_W;
  localparam logic [ADDR_W-1:0] ID_MFR_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ID_DEV_ADDR  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ID_PERM_ADDR = ADDR_W'(3);
  localparam logic [OFFS_W-1:0] ID_LOCK_OFFS = OFFS_W'(2);

  logic [NUM_BLOCKS-1:0] lockBits;
  logic                  eraseErr, progErr, seqErr, lockErr;
  logic [BLK_W-1:0]      wrBlk, rdBlk;
  logic [15:0]           statusWord, identWord;

  assign wrBlk        = wrAddr[ADDR_W-1 -: BLK_W];
  assign rdBlk        = rdAddr[ADDR_W-1 -: BLK_W];
  assign targetLocked = lockBits[wrBlk];
  assign anyLocked    = |lockBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockBits <= '0; permLocked <= 1'b0;
      eraseErr <= 1'b0; progErr <= 1'b0; seqErr <= 1'b0; lockErr <= 1'b0;
    end else begin
      if (strobes.clrAllLocks) lockBits <= '0;
      else if (strobes.setBlkLock) lockBits[wrBlk] <= 1'b1;
      if (strobes.setPermLock) permLocked <= 1'b1;
      if (strobes.clrErr) begin
        eraseErr <= 1'b0; progErr <= 1'b0; seqErr <= 1'b0; lockErr <= 1'b0;
      end
      if (strobes.setEraseErr) eraseErr <= 1'b1;
      if (strobes.setProgErr)  progErr  <= 1'b1;
      if (strobes.setSeqErr)   seqErr   <= 1'b1;
      if (strobes.setLockErr)  lockErr  <= 1'b1;
    end
  end

  assign statusWord = {8'h00, !(strobes.busy && !strobes.suspended), strobes.suspended,
                       eraseErr, progErr, seqErr, 1'b0, lockErr, 1'b0};

  always_comb begin
    if (rdAddr == ID_MFR_ADDR)                 identWord = 16'h00B0;
    else if (rdAddr == ID_DEV_ADDR)            identWord = 16'h00E9;
    else if (rdAddr == ID_PERM_ADDR)           identWord = {15'b0, permLocked};
    else if (rdAddr[OFFS_W-1:0] == ID_LOCK_OFFS) identWord = {15'b0, lockBits[rdBlk]};
    else                                       identWord = 16'h0000;
  end

  always_comb begin
    if (strobes.busy && !strobes.suspended) rdData = statusWord;
    else begin
      case (strobes.mode)
        RM_ARRAY: rdData = arrayData;
        RM_IDENT: rdData = identWord;
        default:  rdData = statusWord;
      endcase
    end
  end

  assert_perm_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    permLocked |=> permLocked);
  assert_locks_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    permLocked |=> $stable(lockBits));
  assert_clear_errs_R13: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrErr |=> (!seqErr && !lockErr));
  assert_busy_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && !strobes.suspended) |-> (rdData[7] == 1'b0));
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_BLOCKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [15:0]       rdData,
  input  logic [15:0]       arrayData,
  output logic              opStart,
  output logic [1:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [15:0]       opData,
  output logic              suspendReq,
  output logic              resumeReq,
  input  logic              opDone,
  input  logic              opErr
);
  seqStrobes_t strobes;
  logic targetLocked, anyLocked, permLocked;

  fcs_control #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .opDone(opDone), .opErr(opErr), .targetLocked(targetLocked),
    .anyLocked(anyLocked), .permLocked(permLocked), .strobes(strobes),
    .opStart(opStart), .opKind(opKind), .opAddr(opAddr), .opData(opData),
    .suspendReq(suspendReq), .resumeReq(resumeReq)
  );

  fcs_datapath #(.ADDR_W(ADDR_W), .NUM_BLOCKS(NUM_BLOCKS)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .arrayData(arrayData), .rdData(rdData), .targetLocked(targetLocked),
    .anyLocked(anyLocked), .permLocked(permLocked)
  );
endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int ADDR_W = 8;
  localparam int NBLK   = 4;
  localparam int BSIZE  = (1 << ADDR_W) / NBLK;
  localparam int LAT    = 12;

  logic clk = 0, rstN = 0, wrEn = 0, opDone = 0, opErr = 0;
  logic [ADDR_W-1:0] wrAddr = '0, rdAddr = '0, opAddr;
  logic [15:0] wrData = '0, rdData, opData, arrayData = 16'h5A3C;
  logic opStart, suspendReq, resumeReq;
  logic [1:0] opKind;
  int total = 0, fails = 0, cnt = 0;
  logic stubSusp = 0;
  logic [NBLK-1:0] lockModel = '0;
  logic permModel = 0;

  always #4 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .NUM_BLOCKS(NBLK)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .arrayData(arrayData), .opStart(opStart),
    .opKind(opKind), .opAddr(opAddr), .opData(opData), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .opDone(opDone), .opErr(opErr));

  // stub back end: fixed latency, pauses while suspended
  always @(posedge clk) begin
    if (!rstN) begin cnt <= 0; stubSusp <= 0; opDone <= 0; end
    else begin
      opDone <= 1'b0;
      if (opStart) cnt <= LAT;
      else if (cnt != 0 && !stubSusp && !suspendReq) begin
        cnt <= cnt - 1;
        if (cnt == 1) opDone <= 1'b1;
      end
      if (suspendReq) stubSusp <= 1'b1;
      if (resumeReq) stubSusp <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin fails++; $display("FAIL %s: got %h expected %h", tag, act, exp); end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic waitDone();
    repeat (LAT + 4) @(negedge clk);
  endtask

  function automatic logic [15:0] st(bit rdy, bit sus, bit ee, bit pe, bit se, bit le);
    return {8'h00, rdy, sus, ee, pe, se, 1'b0, le, 1'b0};
  endfunction

  function automatic logic [15:0] idExp(int a);
    if (a == 0) return 16'h00B0;
    if (a == 1) return 16'h00E9;
    if (a == 3) return {15'b0, permModel};
    if (a % BSIZE == 2) return {15'b0, lockModel[a / BSIZE]};
    return 16'h0000;
  endfunction

  task automatic chkStat(input logic [15:0] exp, input string tag);
    chk(rdData == exp, tag, rdData, exp);
  endtask

  task automatic sweepId(input string tag);
    wr(8'h11, 16'h0090);
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      rdAddr = ADDR_W'(a); #1;
      chk(rdData == idExp(a), tag, rdData, idExp(a));
    end
    rdAddr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got %h expected %h", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rstN = 1; @(negedge clk);
    // R1 reset state
    chk(rdData == arrayData, "R1 array mode", rdData, arrayData);
    chk(!opStart && !suspendReq && !resumeReq, "R1 no request", {opStart, suspendReq, resumeReq}, 0);
    // R2 address and high byte ignored
    wr(8'h37, 16'hAB70); chkStat(st(1,0,0,0,0,0), "R2/R1 status via 0x70");
    wr(8'hC4, 16'h12FF); chk(rdData == arrayData, "R2 back to array", rdData, arrayData);
    sweepId("R3 ident, no locks");
    // R8 lock each block in turn, sweep identifier space
    for (int b = 0; b < NBLK; b++) begin
      wr(ADDR_W'(b * BSIZE + 5), 16'h0060); wr(ADDR_W'(b * BSIZE + 9), 16'h0001);
      lockModel[b] = 1'b1;
      sweepId("R8/R3 block lock set");
    end
    wr(8'h00, 16'h0060); wr(8'h00, 16'h00D0); lockModel = '0;
    sweepId("R8 clear all locks");
    // R6 bad lock sub-code
    wr(8'h00, 16'h0060); wr(8'h40, 16'h0077);
    chkStat(st(1,0,0,0,1,0), "R6 lock bad subcode");
    sweepId("R6 locks unchanged");
    wr(8'h00, 16'h0050); wr(8'h00, 16'h0070);
    chkStat(st(1,0,0,0,0,0), "R13 clear seqErr");
    // R4/R6 sweep of erase confirm byte
    for (int c = 0; c < 256; c++) begin
      wr(8'h00, 16'h0020); wr(8'h46, 16'(c));
      if (c == 8'hD0) begin
        chk(opStart && opKind == 2'd0 && opAddr == 8'h46, "R4 block erase start", {opStart, opKind, opAddr}, {1'b1, 2'd0, 8'h46});
        chkStat(st(0,0,0,0,0,0), "R10 busy status");
        waitDone();
        chkStat(st(1,0,0,0,0,0), "R12 done clears busy");
      end else begin
        chk(!opStart, "R6 no start on bad confirm", opStart, 0);
        chkStat(st(1,0,0,0,1,0), "R6 seqErr");
        wr(8'h00, 16'h0050);
      end
    end
    // R4 chip erase
    wr(8'h00, 16'h0030); wr(8'h00, 16'h00D0);
    chk(opStart && opKind == 2'd1, "R4 chip erase", {opStart, opKind}, {1'b1, 2'd1});
    waitDone();
    // R5 program with both opening codes
    wr(8'h00, 16'h0040); wr(8'h85, 16'h1234);
    chk(opStart && opKind == 2'd2 && opAddr == 8'h85 && opData == 16'h1234, "R5 program 0x40",
        {opKind, opAddr, opData}, {2'd2, 8'h85, 16'h1234});
    waitDone();
    wr(8'h00, 16'h0010); wr(8'h07, 16'hBEEF);
    chk(opStart && opKind == 2'd2 && opData == 16'hBEEF, "R5 program 0x10", opData, 16'hBEEF);
    waitDone();
    // R7 locked targets
    wr(8'h82, 16'h0060); wr(8'h82, 16'h0001);
    wr(8'h00, 16'h0020); wr(8'h8C, 16'h00D0);
    chk(!opStart, "R7 erase locked refused", opStart, 0);
    chkStat(st(1,0,0,0,0,1), "R7 lockErr erase");
    wr(8'h00, 16'h0040); wr(8'hBF, 16'h5555);
    chk(!opStart, "R7 program locked refused", opStart, 0);
    wr(8'h00, 16'h0030); wr(8'h00, 16'h00D0);
    chk(!opStart, "R7 chip erase refused", opStart, 0);
    wr(8'h00, 16'h0020); wr(8'hC1, 16'h00D0);
    chk(opStart && opAddr == 8'hC1, "R7 unlocked block ok", opAddr, 8'hC1);
    waitDone();
    wr(8'h00, 16'h0050); wr(8'h00, 16'h0060); wr(8'h00, 16'h00D0);
    // R10 writes ignored while busy
    wr(8'h00, 16'h0040); wr(8'h10, 16'h0001);
    wr(8'h00, 16'h00FF);
    chkStat(st(0,0,0,0,0,0), "R10 status despite 0xFF");
    wr(8'h00, 16'h0060); wr(8'h00, 16'h0001); wr(8'h00, 16'h0090);
    waitDone();
    chkStat(st(1,0,0,0,0,0), "R10 0x90 ignored while busy");
    sweepId("R10 lock write ignored while busy");
    // R11 suspend / resume
    wr(8'h00, 16'h0020); wr(8'h20, 16'h00D0);
    wr(8'h00, 16'h00B0);
    chk(suspendReq, "R11 suspend pulse", suspendReq, 1);
    chkStat(st(1,1,0,0,0,0), "R11 suspended status");
    wr(8'h00, 16'h0020);
    wr(8'h20, 16'h00D0);
    chk(resumeReq && !opStart, "R11 resume not confirm", {resumeReq, opStart}, 2'b10);
    chkStat(st(0,0,0,0,0,0), "R11 running again");
    waitDone();
    chkStat(st(1,0,0,0,0,0), "R12 done after resume");
    // R12 error reporting
    opErr = 1;
    wr(8'h00, 16'h0020); wr(8'h00, 16'h00D0); waitDone();
    chkStat(st(1,0,1,0,0,0), "R12 eraseErr");
    wr(8'h00, 16'h0040); wr(8'h00, 16'h0001); waitDone();
    chkStat(st(1,0,1,1,0,0), "R12 progErr");
    opErr = 0;
    wr(8'h00, 16'h0020); wr(8'h00, 16'h0033);
    wr(8'h00, 16'h0050);
    chkStat(st(1,0,0,0,0,0), "R13 clear all error bits");
    // R9 permanent lock
    wr(8'h03, 16'h0060); wr(8'h03, 16'h0001); lockModel[0] = 1'b1;
    wr(8'h00, 16'h0060); wr(8'h00, 16'h00F1); permModel = 1'b1;
    wr(8'h00, 16'h0060); wr(8'h41, 16'h0001);
    chkStat(st(1,0,0,0,0,1), "R9 set refused");
    wr(8'h00, 16'h0060); wr(8'h00, 16'h00D0);
    sweepId("R9 locks frozen");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule